// File: doc/BRIEF.md
# Transmit Audio Write Buffer with DMA Event Generation

This block sits between a host or DMA write port and a bank of audio serializers on the transmit side. It holds up to 64 words of 32 bits. When the serializer side asks for data, it hands one stored word to each active transmitter lane in a single transfer. It raises a one-cycle DMA event whenever enough free space has opened up, so the host can refill the buffer in bursts rather than word by word.

Two configuration inputs set its behaviour. The per-transfer count is the number of transmit lanes served on each serializer request. The per-event count is the size of the refill burst that each DMA event asks for. The per-event count must be a non-zero multiple of the per-transfer count, and the ratio of the two sets how many serializer transfers occur per DMA request. If the configuration is illegal, the block holds itself idle and flags an error.

With the buffer switched off, the block runs in pass-through mode. Each host word goes straight to lane 0, and each serializer request becomes a DMA event. Both count inputs are ignored in this mode.

Top module: `txf_write_fifo`

## Requirements
- R1: After reset the buffer is empty and `ser_valid_o`, `ser_data_o`, `evt_o`, `overflow_o` and `underrun_o` are all zero.
- R2: In buffer mode the block holds exactly 64 words. Words leave in the order they were written.
- R3: A serializer request that finds at least `xfer_cnt_i` words stored removes that many words. One cycle later `ser_valid_o` is high, lane k (bits 32k+31..32k) holds the k-th oldest word for every k below `xfer_cnt_i`, and all higher lanes are zero.
- R4: While armed, the block pulses `evt_o` for one cycle, one cycle after a cycle in which free space (64 minus occupancy) is at least `evt_cnt_i`. The block is armed after reset, after leaving pass-through or halt, and when re-armed under R5.
- R5: After an event, no further event is raised until `evt_cnt_i` host words have been accepted. The block then re-arms and fires again once the free-space condition holds.
- R6: A host write while 64 words are stored is dropped, even when a serializer request pops words in the same cycle. It sets `overflow_o`, which stays high until reset.
- R7: A serializer request that finds fewer than `xfer_cnt_i` words stored removes nothing and leaves `ser_valid_o` low. It sets `underrun_o`, which stays high until reset.
- R8: With the buffer enabled, `cfg_err_o` is high in the same cycle whenever `xfer_cnt_i` is 0 or above 16, or `evt_cnt_i` is 0 or above 64, or `evt_cnt_i` is not a multiple of `xfer_cnt_i`. While it is high, the buffer is emptied, writes and requests are ignored without setting any flag, and no event or data is produced.
- R9: With `fifo_en_i` low, each host write appears on lane 0 one cycle later with `ser_valid_o` high and the other lanes zero. Each serializer request gives an `evt_o` pulse one cycle later. The count inputs are ignored, `cfg_err_o` stays low and the buffer is emptied.
- R10: With `evt_cnt_i` equal to r times `xfer_cnt_i`, and each event answered by exactly `evt_cnt_i` writes, draining a full buffer gives one event for every r serializer requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects buffer mode, 0 selects pass-through |
| xfer_cnt_i | input | 5 | Words per serializer transfer (number of active transmit lanes) |
| evt_cnt_i | input | 7 | Words requested per DMA event |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write word |
| ser_req_i | input | 1 | Serializer transfer request |
| ser_valid_o | output | 1 | Lane data valid, one-cycle pulse |
| ser_data_o | output | 512 | Sixteen 32-bit lanes; lane k occupies bits 32k+31..32k |
| evt_o | output | 1 | DMA event pulse |
| overflow_o | output | 1 | Sticky dropped-write flag |
| underrun_o | output | 1 | Sticky starved-request flag |
| cfg_err_o | output | 1 | Illegal configuration while the buffer is enabled |

## Verification
`cfg_err_o` is combinational and is checked in the same cycle its inputs change. Lane data, `ser_valid_o`, `evt_o` and both sticky flags all come from a single register stage, so they are due one rising edge after the cycle that carries the write, request or free-space condition. The bench applies inputs on a falling edge and compares every output on the next falling edge against a reference model advanced by one step. Each comparison therefore lands exactly one edge after its stimulus. Directed sequences cover full-buffer overflow with a concurrent pop, underrun, illegal and ignored configurations, and the event-to-transfer ratio. Seeded random traffic with random legal and illegal configurations follows them.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;
  localparam int TXF_DATA_W  = 32;
  localparam int TXF_DEPTH   = 64;
  localparam int TXF_NUM_SER = 16;

  typedef enum logic [1:0] {
    TXF_HALT   = 2'd0,
    TXF_BYPASS = 2'd1,
    TXF_RUN    = 2'd2
  } txf_mode_e;
endpackage

// File: rtl/txf_cfg_check.sv
`timescale 1ns/1ps
module txf_cfg_check #(
  parameter int DEPTH   = 64,
  parameter int NUM_SER = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int XFER_W = $clog2(NUM_SER + 1)
) (
  input  logic [XFER_W-1:0] xfer_cnt_i,
  input  logic [CNT_W-1:0]  evt_cnt_i,
  output logic              cfg_ok_o
);
  logic [DEPTH-1:0] mult_hit;

  // evt_cnt must equal m * xfer_cnt for some m in 1..DEPTH
  for (genvar m = 1; m <= DEPTH; m++) begin : g_mult
    assign mult_hit[m-1] = ((32'(xfer_cnt_i) * 32'(m)) == 32'(evt_cnt_i));
  end

  assign cfg_ok_o = (xfer_cnt_i != '0) && (xfer_cnt_i <= XFER_W'(NUM_SER)) &&
                    (evt_cnt_i != '0) && (evt_cnt_i <= CNT_W'(DEPTH)) &&
                    (|mult_hit);
endmodule

// File: rtl/txf_store.sv
`timescale 1ns/1ps
module txf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LANES  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LN_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    push_i,
  input  logic [DATA_W-1:0]       push_data_i,
  input  logic                    pop_i,
  input  logic [LN_W-1:0]         pop_n_i,
  output logic [CNT_W-1:0]        count_o,
  output logic [LANES*DATA_W-1:0] lanes_o
);
  // DEPTH must be a power of two: pointers wrap by truncation
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      count_q <= count_q + CNT_W'(push_i) - (pop_i ? CNT_W'(pop_n_i) : CNT_W'(0));
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes_o[k*DATA_W +: DATA_W] = mem_q[rd_ptr_q + PTR_W'(k)];
  end

  assign count_o = count_q;
endmodule

// File: rtl/txf_evt_gen.sv
`timescale 1ns/1ps
module txf_evt_gen #(
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bypass_i,
  input  logic             ser_req_i,
  input  logic             push_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] evt_cnt_i,
  output logic             evt_o
);
  logic             armed_q, evt_q;
  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] free_w;

  assign free_w = CNT_W'(DEPTH) - count_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      pend_q  <= '0;
      evt_q   <= 1'b0;
    end else if (!run_i) begin
      armed_q <= 1'b1;
      pend_q  <= '0;
      evt_q   <= bypass_i & ser_req_i;
    end else begin
      evt_q <= 1'b0;
      if (armed_q && (free_w >= evt_cnt_i)) begin
        evt_q   <= 1'b1;
        armed_q <= 1'b0;
        pend_q  <= evt_cnt_i;
      end else if (!armed_q && push_i) begin
        // re-arm once the requested burst has fully arrived
        if (pend_q == CNT_W'(1)) armed_q <= 1'b1;
        pend_q <= pend_q - CNT_W'(1);
      end
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/txf_write_fifo.sv
`timescale 1ns/1ps
module txf_write_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W  = TXF_DATA_W,
  parameter int DEPTH   = TXF_DEPTH,
  parameter int NUM_SER = TXF_NUM_SER,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int XFER_W = $clog2(NUM_SER + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fifo_en_i,
  input  logic [XFER_W-1:0]         xfer_cnt_i,
  input  logic [CNT_W-1:0]          evt_cnt_i,
  input  logic                      wr_valid_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      ser_req_i,
  output logic                      ser_valid_o,
  output logic [NUM_SER*DATA_W-1:0] ser_data_o,
  output logic                      evt_o,
  output logic                      overflow_o,
  output logic                      underrun_o,
  output logic                      cfg_err_o
);
  txf_mode_e                 mode;
  logic                      cfg_ok, run, byp;
  logic [CNT_W-1:0]          count_w;
  logic [NUM_SER*DATA_W-1:0] lane_w, lane_masked, data_d;
  logic                      full, enough, push, pop, ovf_set, udr_set, byp_wr;
  logic                      valid_q, ovf_q, udr_q;
  logic [NUM_SER*DATA_W-1:0] data_q;

  txf_cfg_check #(.DEPTH(DEPTH), .NUM_SER(NUM_SER)) u_cfg (
    .xfer_cnt_i (xfer_cnt_i),
    .evt_cnt_i  (evt_cnt_i),
    .cfg_ok_o   (cfg_ok)
  );

  always_comb begin
    if (!fifo_en_i)  mode = TXF_BYPASS;
    else if (cfg_ok) mode = TXF_RUN;
    else             mode = TXF_HALT;
  end

  assign run       = (mode == TXF_RUN);
  assign byp       = (mode == TXF_BYPASS);
  assign cfg_err_o = (mode == TXF_HALT);

  assign full    = (count_w == CNT_W'(DEPTH));
  assign enough  = (count_w >= CNT_W'(xfer_cnt_i));
  assign push    = run & wr_valid_i & ~full;
  assign ovf_set = run & wr_valid_i & full;
  assign pop     = run & ser_req_i & enough;
  assign udr_set = run & ser_req_i & ~enough;
  assign byp_wr  = byp & wr_valid_i;

  txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(NUM_SER)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (~run),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .pop_n_i     (xfer_cnt_i),
    .count_o     (count_w),
    .lanes_o     (lane_w)
  );

  txf_evt_gen #(.DEPTH(DEPTH)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .bypass_i  (byp),
    .ser_req_i (ser_req_i),
    .push_i    (push),
    .count_i   (count_w),
    .evt_cnt_i (evt_cnt_i),
    .evt_o     (evt_o)
  );

  for (genvar k = 0; k < NUM_SER; k++) begin : g_mask
    assign lane_masked[k*DATA_W +: DATA_W] =
      (XFER_W'(k) < xfer_cnt_i) ? lane_w[k*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    data_d = '0;
    if (pop)         data_d = lane_masked;
    else if (byp_wr) data_d[DATA_W-1:0] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ovf_q   <= 1'b0;
      udr_q   <= 1'b0;
    end else begin
      valid_q <= pop | byp_wr;
      data_q  <= data_d;
      if (ovf_set) ovf_q <= 1'b1;
      if (udr_set) udr_q <= 1'b1;
    end
  end

  assign ser_valid_o = valid_q;
  assign ser_data_o  = data_q;
  assign overflow_o  = ovf_q;
  assign underrun_o  = udr_q;
endmodule

// File: rtl/txf_write_fifo_chk.sv
`timescale 1ns/1ps
module txf_write_fifo_chk #(
  parameter int DEPTH   = 64,
  parameter int NUM_SER = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int XFER_W = $clog2(NUM_SER + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_i,
  input logic              wr_valid_i,
  input logic              ser_req_i,
  input logic [XFER_W-1:0] xfer_cnt_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              ser_valid_o,
  input logic              evt_o,
  input logic              overflow_o,
  input logic              underrun_o,
  input logic              cfg_err_o
);
  logic active;
  assign active = fifo_en_i & ~cfg_err_o;

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  a_r3_pop_amount: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ser_req_i && !wr_valid_i && (count_i >= CNT_W'(xfer_cnt_i)))
    |=> (ser_valid_o && (count_i == $past(count_i) - CNT_W'($past(xfer_cnt_i)))));

  a_r4_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && active) |=> !evt_o);

  a_r6_ovf_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && wr_valid_i && !ser_req_i && (count_i == CNT_W'(DEPTH)))
    |=> (overflow_o && (count_i == CNT_W'(DEPTH))));

  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r7_udr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ser_req_i && (count_i < CNT_W'(xfer_cnt_i)))
    |=> (underrun_o && !ser_valid_o));

  a_r7_udr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (!ser_valid_o && !evt_o && (count_i == '0)));

  a_r9_bypass_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !cfg_err_o);
endmodule

bind txf_write_fifo txf_write_fifo_chk #(.DEPTH(DEPTH), .NUM_SER(NUM_SER)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .wr_valid_i  (wr_valid_i),
  .ser_req_i   (ser_req_i),
  .xfer_cnt_i  (xfer_cnt_i),
  .count_i     (count_w),
  .ser_valid_o (ser_valid_o),
  .evt_o       (evt_o),
  .overflow_o  (overflow_o),
  .underrun_o  (underrun_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/txf_write_fifo_test.sv
`timescale 1ns/1ps
module txf_write_fifo_test;
  localparam int DW    = 32;
  localparam int DEPTH = 64;
  localparam int NS    = 16;
  localparam int CW    = 7;
  localparam int XW    = 5;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           fifo_en_i = 1'b0;
  logic [XW-1:0]  xfer_cnt_i = '0;
  logic [CW-1:0]  evt_cnt_i = '0;
  logic           wr_valid_i = 1'b0;
  logic [DW-1:0]  wr_data_i = '0;
  logic           ser_req_i = 1'b0;
  logic           ser_valid_o;
  logic [NS*DW-1:0] ser_data_o;
  logic           evt_o, overflow_o, underrun_o, cfg_err_o;

  always #2.5 clk_i = ~clk_i;

  txf_write_fifo uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i),
    .xfer_cnt_i(xfer_cnt_i), .evt_cnt_i(evt_cnt_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .ser_req_i(ser_req_i),
    .ser_valid_o(ser_valid_o), .ser_data_o(ser_data_o), .evt_o(evt_o),
    .overflow_o(overflow_o), .underrun_o(underrun_o), .cfg_err_o(cfg_err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  int unsigned q[$];
  bit m_armed = 1'b1, m_ovf = 1'b0, m_udr = 1'b0, last_evt = 1'b0;
  int m_pend = 0;
  bit en = 1'b0;
  int xfer = 1, evt = 1;
  int unsigned wd = 32'h1000;

  function automatic bit cfg_ok_f(int x, int e);
    return (x >= 1) && (x <= NS) && (e >= 1) && (e <= DEPTH) && ((e % x) == 0);
  endfunction

  task automatic chk(input string tag, input logic [NS*DW-1:0] act, input logic [NS*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; fifo_en_i = 1'b0; wr_valid_i = 1'b0; ser_req_i = 1'b0;
    xfer_cnt_i = '0; evt_cnt_i = '0;
    cyc(); cyc();
    q.delete(); m_armed = 1'b1; m_pend = 0; m_ovf = 1'b0; m_udr = 1'b0;
    rst_ni = 1'b1;
  endtask

  // one cycle: drive, advance, compare against the model
  task automatic step(input bit wr, input bit req);
    bit ok, run, byp, e_valid, e_evt;
    logic [NS*DW-1:0] e_data;
    int sz;
    ok  = cfg_ok_f(xfer, evt);
    run = en && ok;
    byp = !en;
    fifo_en_i = en; xfer_cnt_i = XW'(xfer); evt_cnt_i = CW'(evt);
    wr_valid_i = wr; wr_data_i = wd; ser_req_i = req;
    #1;
    chk("R8 cfg_err_o", cfg_err_o, en && !ok);
    e_data = '0; e_valid = 1'b0; e_evt = 1'b0; sz = q.size();
    if (!run) begin
      q.delete(); m_armed = 1'b1; m_pend = 0;
      e_evt = byp && req;
      if (byp && wr) begin e_valid = 1'b1; e_data[DW-1:0] = wd; end
    end else begin
      if (m_armed && (DEPTH - sz) >= evt) begin
        e_evt = 1'b1; m_armed = 1'b0; m_pend = evt;
      end else if (!m_armed && wr && sz != DEPTH) begin
        m_pend--;
        if (m_pend == 0) m_armed = 1'b1;
      end
      if (req) begin
        if (sz >= xfer) begin
          e_valid = 1'b1;
          for (int k = 0; k < xfer; k++) e_data[k*DW +: DW] = q.pop_front();
        end else m_udr = 1'b1;
      end
      if (wr) begin
        if (sz != DEPTH) q.push_back(wd);
        else m_ovf = 1'b1;
      end
    end
    if (wr) wd++;
    cyc();
    wr_valid_i = 1'b0; ser_req_i = 1'b0;
    chk(byp ? "R9 ser_valid_o" : "R3 ser_valid_o", ser_valid_o, e_valid);
    chk(byp ? "R9 ser_data_o" : "R3 ser_data_o", ser_data_o, e_data);
    chk(e_evt ? "R4 evt_o" : "R5 evt_o", evt_o, e_evt);
    chk("R6 overflow_o", overflow_o, m_ovf);
    chk("R7 underrun_o", underrun_o, m_udr);
    last_evt = evt_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n_ev, n_rq;
    void'($urandom(32'd2024));

    // R1: reset state
    do_reset();
    chk("R1 ser_valid_o", ser_valid_o, 0);
    chk("R1 ser_data_o", ser_data_o, 0);
    chk("R1 evt_o", evt_o, 0);
    chk("R1 overflow_o", overflow_o, 0);
    chk("R1 underrun_o", underrun_o, 0);

    // R2/R6: fill to capacity, overflow with a concurrent pop
    en = 1; xfer = 1; evt = 64;
    step(0, 0);
    chk("R4 first event on empty buffer", evt_o, 1);
    for (int i = 0; i < 64; i++) step(1, 0);
    chk("R2 no overflow at capacity", overflow_o, 0);
    step(1, 1);
    chk("R6 overflow on full with pop", overflow_o, 1);
    for (int i = 0; i < 63; i++) step(0, 1);
    chk("R2 last stored word delivered", ser_valid_o, 1);
    step(0, 1);
    chk("R7 underrun after drain", underrun_o, 1);

    // R3/R7: wide transfers
    do_reset();
    en = 1; xfer = 16; evt = 48;
    for (int i = 0; i < 20; i++) step(1, 0);
    step(0, 1);
    chk("R3 sixteen lanes valid", ser_valid_o, 1);
    step(0, 1);
    chk("R7 short request no data", ser_valid_o, 0);
    chk("R7 short request flag", underrun_o, 1);
    xfer = 4; evt = 8;
    step(0, 1);
    chk("R3 four lanes after short request", ser_valid_o, 1);

    // R8: illegal configuration halts and flushes
    do_reset();
    en = 1; xfer = 2; evt = 8;
    for (int i = 0; i < 6; i++) step(1, 0);
    xfer = 4; evt = 6;
    step(1, 1);
    chk("R8 error flag", cfg_err_o, 1);
    chk("R8 no flag while halted", underrun_o, 0);
    xfer = 4; evt = 0;  step(1, 0);
    xfer = 0; evt = 4;  step(0, 1);
    xfer = 17; evt = 34; step(0, 0);
    xfer = 2; evt = 66; step(0, 0);
    xfer = 2; evt = 8;
    step(0, 1);
    chk("R8 buffer flushed by halt", underrun_o, 1);

    // R9: pass-through ignores counts
    do_reset();
    en = 0; xfer = 0; evt = 3;
    step(1, 0);
    chk("R9 lane0 data", ser_data_o[DW-1:0], wd - 1);
    step(0, 1);
    chk("R9 event per request", evt_o, 1);
    chk("R9 no error in pass-through", cfg_err_o, 0);
    step(1, 1);

    // R10: one event every four transfers at ratio 4
    do_reset();
    en = 1; xfer = 4; evt = 16;
    while (q.size() < DEPTH) begin
      step(0, 0);
      if (last_evt) for (int i = 0; i < 16; i++) step(1, 0);
    end
    n_ev = 0; n_rq = 0;
    for (int i = 0; i < 32; i++) begin
      step(0, 1); n_rq++;
      step(0, 0);
      if (last_evt) begin
        n_ev++;
        for (int j = 0; j < 16; j++) step(1, 0);
      end
    end
    chk("R10 events per 32 transfers", n_ev, n_rq / 4);

    // random traffic
    do_reset();
    for (int blk = 0; blk < 20; blk++) begin
      en = (($urandom % 8) != 0);
      xfer = 1 + ($urandom % NS);
      evt = xfer * (1 + ($urandom % (DEPTH / xfer)));
      if (($urandom % 6) == 0) evt = $urandom % 70;
      for (int c = 0; c < 250; c++)
        step(($urandom % 100) < 55, ($urandom % 100) < 12);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule